// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This unit gathers up to sixteen device-side interrupt sources and presents them to a host through a small word-addressed register port. Each source is watched for a low-to-high transition. A transition sets a sticky bit in a status register, and that bit stays set until the host removes it.

The host controls which pending bits reach its interrupt line through a mask register. In the mask, a 1 blocks a bit and a 0 lets it through. The mask can be written whole, or it can be changed one bit at a time through a write-one-to-set alias and a write-one-to-clear alias.

The host can read the status in two ways. One view leaves the status untouched. The other view empties the status as it is read. The host can also retire chosen bits through an acknowledge register. A single host interrupt line is driven from the unmasked pending bits. The active level of that line is chosen by a configuration input.

Top module: `hirq_unit`

Register map (word addresses on `bus_addr`):

| Address | Access | Function |
|---|---|---|
| 0 | read/write | mask |
| 1 | write-only | mask set |
| 2 | write-only | mask clear |
| 3 | read-only | status, non-destructive read |
| 4 | read-only | status, clear-on-read |
| 5 | write-only | acknowledge |
| 6, 7 | none | unmapped |

## Requirements
- R1: While reset is held and just after it is released, the mask reads 0x0001 (only source 0 blocked), the status reads 0x0000, `bus_rvalid` is 0 and the host line is at its inactive level.
- R2: A status bit sets on the clock edge at which its source is first seen high after having been low. A source that stays high sets its bit only once.
- R3: The mask is read and written whole at address 0. A mask bit of 1 keeps the matching status bit off the host line; a mask bit of 0 lets it through.
- R4: A write to address 1 sets every mask bit written as 1 and leaves the other mask bits as they were.
- R5: A write to address 2 clears every mask bit written as 1 and leaves the other mask bits as they were.
- R6: A read of address 3 returns the status and does not change it.
- R7: A read of address 4 returns the status as it stood before the read, and then clears every status bit.
- R8: A write to address 5 clears every status bit written as 1. Bits written as 0 have no effect.
- R9: When a source transition arrives in the same cycle as an acknowledge or a clear-on-read of its bit, the bit ends up set.
- R10: The host line is the OR of (status AND NOT mask), registered once. It is driven high when that OR is 1, unless `irq_active_low` is 1, in which case the line is inverted.
- R11: Reads of address 1, 2, 5, 6 or 7 return 0. Writes to address 3, 4, 6 or 7 change neither the mask nor the status.
- R12: Read data appears on `bus_rdata` with `bus_rvalid` high exactly one cycle after a read request. `bus_rvalid` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_active_low | input | 1 | 1 selects an active-low host line |
| src_in | input | NSRC | Device-side interrupt sources |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data |
| bus_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Host interrupt line |

## Verification
A source edge or a register write changes the status or the mask on the very next clock edge. The host line follows one edge after that, because of its output register, so the bench waits two falling edges before it samples the line. Read data is due one edge after the request. The driver therefore queues the expected word when it issues the read, and a monitor on the falling edge pops that word only in the cycle where `bus_rvalid` is high. The same-cycle collision cases are created by changing a source on the same falling edge that issues the acknowledge or the clear-on-read.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int HIRQ_AW = 3;

  localparam logic [HIRQ_AW-1:0] A_MASK  = 3'd0;
  localparam logic [HIRQ_AW-1:0] A_MSET  = 3'd1;
  localparam logic [HIRQ_AW-1:0] A_MCLR  = 3'd2;
  localparam logic [HIRQ_AW-1:0] A_PEEK  = 3'd3;
  localparam logic [HIRQ_AW-1:0] A_TAKE  = 3'd4;
  localparam logic [HIRQ_AW-1:0] A_ACK   = 3'd5;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic ack;
    logic peek_rd;
    logic take_rd;
  } hirq_strobe_t;
endpackage

// File: rtl/hirq_edge.sv
module hirq_edge #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] rise
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= src[i];
    end
    assign rise[i] = src[i] & ~seen_q;
  end
endmodule

// File: rtl/hirq_mask.sv
module hirq_mask #(
  parameter int              NSRC     = 16,
  parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_all,
  input  logic            wr_set,
  input  logic            wr_clr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask
);
  function automatic logic [NSRC-1:0] next_mask(
    input logic [NSRC-1:0] cur, input logic [NSRC-1:0] d,
    input logic all, input logic s, input logic c);
    logic [NSRC-1:0] r;
    r = cur;
    if (all) r = d;
    if (s)   r = r | d;
    if (c)   r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= MASK_RST;
    else        mask <= next_mask(mask, wdata, wr_all, wr_set, wr_clr);
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask & $past(wdata)) == $past(wdata)));
  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask & $past(wdata)) == '0));
  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
endmodule

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] rise,
  input  logic            ack_en,
  input  logic [NSRC-1:0] ack_bits,
  input  logic            take_en,
  output logic [NSRC-1:0] status
);
  function automatic logic [NSRC-1:0] wipe_vec(
    input logic ack, input logic [NSRC-1:0] bits, input logic take);
    return (ack ? bits : '0) | (take ? '1 : '0);
  endfunction

  logic [NSRC-1:0] wipe;
  assign wipe = wipe_vec(ack_en, ack_bits, take_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~wipe) | rise;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> ((status & $past(ack_bits) & ~$past(rise)) == '0));
  // R7
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |=> (status == $past(rise)));
endmodule

// File: rtl/hirq_regport.sv
module hirq_regport
  import hirq_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [HIRQ_AW-1:0] bus_addr,
  input  logic [NSRC-1:0]    status,
  input  logic [NSRC-1:0]    mask,
  output hirq_strobe_t       strb,
  output logic [NSRC-1:0]    rdata,
  output logic               rvalid
);
  logic wr_go, rd_go, rd_void;

  assign wr_go = bus_sel & bus_wr;
  assign rd_go = bus_sel & ~bus_wr;

  always_comb begin
    strb          = '0;
    strb.mask_wr  = wr_go & (bus_addr == A_MASK);
    strb.mask_set = wr_go & (bus_addr == A_MSET);
    strb.mask_clr = wr_go & (bus_addr == A_MCLR);
    strb.ack      = wr_go & (bus_addr == A_ACK);
    strb.peek_rd  = rd_go & (bus_addr == A_PEEK);
    strb.take_rd  = rd_go & (bus_addr == A_TAKE);
  end

  assign rd_void = rd_go & (bus_addr != A_MASK) & (bus_addr != A_PEEK)
                         & (bus_addr != A_TAKE);

  function automatic logic [NSRC-1:0] read_mux(
    input logic [HIRQ_AW-1:0] a, input logic [NSRC-1:0] st,
    input logic [NSRC-1:0] mk);
    case (a)
      A_MASK:         return mk;
      A_PEEK, A_TAKE: return st;
      default:        return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= read_mux(bus_addr, status, mask);
    end
  end

  // R11
  void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_void |=> (rdata == '0));
  // R12
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rvalid);
  // R12
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rvalid);
  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
endmodule

// File: rtl/hirq_unit.sv
module hirq_unit
  import hirq_pkg::*;
#(
  parameter int              NSRC     = 16,
  parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_active_low,
  input  logic [NSRC-1:0]    src_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [HIRQ_AW-1:0] bus_addr,
  input  logic [NSRC-1:0]    bus_wdata,
  output logic [NSRC-1:0]    bus_rdata,
  output logic               bus_rvalid,
  output logic               host_irq
);
  hirq_strobe_t    strb;
  logic [NSRC-1:0] rise, status, mask;
  logic            pend_any, irq_q;

  hirq_edge #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src(src_in), .rise(rise));

  hirq_regport #(.NSRC(NSRC)) u_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .status(status), .mask(mask), .strb(strb),
    .rdata(bus_rdata), .rvalid(bus_rvalid));

  hirq_mask #(.NSRC(NSRC), .MASK_RST(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_all(strb.mask_wr), .wr_set(strb.mask_set),
    .wr_clr(strb.mask_clr), .wdata(bus_wdata), .mask(mask));

  hirq_status #(.NSRC(NSRC)) u_status (
    .clk(clk), .rst_n(rst_n), .rise(rise), .ack_en(strb.ack),
    .ack_bits(bus_wdata), .take_en(strb.take_rd), .status(status));

  function automatic logic any_open(input logic [NSRC-1:0] st,
                                    input logic [NSRC-1:0] mk);
    return |(st & ~mk);
  endfunction

  assign pend_any = any_open(status, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

  assign host_irq = irq_q ^ irq_active_low;

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((host_irq ^ irq_active_low) == $past(pend_any)));
  // R6
  peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.peek_rd |=> (status == ($past(status) | $past(rise))));
  // R7
  take_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.take_rd |=> (bus_rdata == $past(status)));
  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in != '0) |=> ((status | ~$past(rise)) == '1));
endmodule

// File: tb/hirq_unit_tb.sv
`timescale 1ns/1ps
module hirq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_active_low = 1'b0;
  logic [15:0] src_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        host_irq;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  hirq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .irq_active_low(irq_active_low), .src_in(src_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .host_irq(host_irq));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // monitor: pops expected read words when data is presented
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R12 unexpected rvalid", 16'h1, 16'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic do_write(logic [2:0] a, logic [15:0] d, logic [15:0] s);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_in = s;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(logic [2:0] a, logic [15:0] e, string tag, logic [15:0] s);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; src_in = s;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(int b);
    @(negedge clk); src_in[b] = 1'b1;
    @(negedge clk); src_in[b] = 1'b0;
  endtask

  task automatic irq_is(logic e, string req);
    repeat (2) @(negedge clk);
    check(req, {15'b0, host_irq}, {15'b0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {15'b0, host_irq}, 16'h0);
    check("R1 rvalid in reset", {15'b0, bus_rvalid}, 16'h0);
    check("R1 rdata in reset", bus_rdata, 16'h0);
    rst_n = 1'b1;
    do_read(3'd0, 16'h0001, "R1 mask reset", src_in);
    do_read(3'd3, 16'h0000, "R1 status reset", src_in);

    pulse(0);
    irq_is(1'b0, "R3 masked bit0");
    do_read(3'd3, 16'h0001, "R2 edge latched", src_in);
    do_read(3'd3, 16'h0001, "R6 peek repeat", src_in);

    @(negedge clk); src_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    do_read(3'd4, 16'h0009, "R7 take returns", src_in);
    do_read(3'd3, 16'h0000, "R7 cleared / R2 level once", src_in);
    @(negedge clk); src_in[3] = 1'b0;

    do_write(3'd2, 16'h0001, src_in);
    check("R12 no rvalid after write", {15'b0, bus_rvalid}, 16'h0);
    do_read(3'd0, 16'h0000, "R5 mask clear", src_in);
    pulse(0);
    irq_is(1'b1, "R10 irq asserts");
    do_write(3'd5, 16'h0001, src_in);
    irq_is(1'b0, "R8 ack drops irq");
    do_read(3'd3, 16'h0000, "R8 ack clears", src_in);

    do_write(3'd1, 16'h00F0, src_in);
    do_read(3'd0, 16'h00F0, "R4 mask set", src_in);
    pulse(5);
    irq_is(1'b0, "R3 masked bit5");
    do_write(3'd0, 16'h0000, src_in);
    irq_is(1'b1, "R3 unmask whole");
    do_write(3'd0, 16'hFFFF, src_in);
    irq_is(1'b0, "R3 mask whole");
    do_read(3'd0, 16'hFFFF, "R3 mask readback", src_in);

    @(negedge clk); irq_active_low = 1'b1;
    #1 check("R10 active-low idle", {15'b0, host_irq}, 16'h1);
    do_write(3'd2, 16'h0020, src_in);
    irq_is(1'b0, "R10 active-low asserted");
    @(negedge clk); irq_active_low = 1'b0;
    #1 check("R10 active-high asserted", {15'b0, host_irq}, 16'h1);
    do_write(3'd5, 16'hFFFF, src_in);
    irq_is(1'b0, "R8 ack all");

    pulse(7);
    do_write(3'd5, 16'h0080, 16'h0080);
    do_read(3'd3, 16'h0080, "R9 rise beats ack", 16'h0080);
    do_read(3'd4, 16'h0080, "R9 take old value", 16'h0280);
    do_read(3'd3, 16'h0200, "R9 rise beats take", 16'h0280);
    @(negedge clk); src_in = '0;
    do_write(3'd5, 16'hFFFF, src_in);

    pulse(2);
    do_write(3'd3, 16'hFFFF, src_in);
    do_write(3'd4, 16'hFFFF, src_in);
    do_write(3'd6, 16'h0000, src_in);
    do_read(3'd3, 16'h0004, "R11 status after ro writes", src_in);
    do_read(3'd0, 16'hFFDF, "R11 mask after ro writes", src_in);
    for (int a = 1; a < 8; a++) begin
      if (a == 1 || a == 2 || a == 5 || a == 6 || a == 7)
        do_read(3'(a), 16'h0000, "R11 wo read zero", src_in);
    end
    do_read(3'd3, 16'h0004, "R11 status after wo reads", src_in);

    repeat (3) @(negedge clk);
    check("R12 queue drained", 16'(exp_q.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule